// File: doc/BRIEF.md
# External Bus Strobe Sequencer

The block controls one chip-select region of an external parallel memory bus. It serves asynchronous SRAM-like, NOR-type and pseudo-SRAM parts. Each access runs on a single timeline of functional-clock ticks. A five-bit counter starts at zero and runs up to a programmed cycle length. Each strobe (chip select, address valid, output enable, write enable) is a window on that timeline, with a programmed start tick and end tick. The window ends differ between reads and writes.

A request interface takes an address, a direction flag and write data. For a read, the block returns the sampled data and a one-clock done pulse. A configuration flag selects between two bus modes. In multiplexed mode, the low address bits share the data bus during an address phase, and write data is switched onto that bus at its own programmable tick. In non-multiplexed mode, the address bus holds the address for the whole access. Timing inputs are static configuration, and the block takes a copy of them when it accepts a request.

Top module: `ext_strobe_seq`

## Requirements
- R1: After reset, and whenever no access is in progress, all four strobes (active low) are high, `ad_oe` is 0, `done` is 0, `req_ready` is 1 and `rdata` is 0 until the first read.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. Tick 0 is the first clock after that edge. The cycle length C is the read or write cycle input, with 0 treated as 1. `done` is high for exactly one clock, at tick C. `req_ready` is low on ticks 0..C-1 and high on tick C, so a request presented there starts the next access with no gap.
- R3: Chip select is low on ticks t with S <= t < E, where S is the assertion tick shared by both directions. For reads, E = A+1. For writes, E = WEoff + gap, where gap is the programmed chip-select gap after WE deassertion.
- R4: Address valid is low on ticks from its assertion tick up to its deassertion tick. The deassertion tick is programmed separately for read and for write. In multiplexed mode, the deassertion tick is raised to at least the assertion tick plus 1.
- R5: The effective access tick is A = min(access, C-1). Read data is taken from `ad_in` at the end of tick A. `rdata` changes at no other time.
- R6: On reads, output enable is low from its start tick up to tick A+1. In multiplexed mode, the start tick is raised to at least the address-phase end (address-valid deassertion tick plus the address hold). Output enable never asserts on a write, and write enable never asserts on a read.
- R7: On writes, write enable is low from its start up to its programmed end. When `cfg_we_sep` is 1, the start is the programmed WE tick. When `cfg_we_sep` is 0, the start is the write-data tick.
- R8: In multiplexed mode, `ad_oe` is 1 and `ad_out` carries the low DW address bits on ticks before the address-phase end. On writes, `ad_oe` is 1 and `ad_out` carries the write data from the write-data tick up to the write chip-select end. In multiplexed mode, the write-data tick is raised to at least the address-phase end. At all other times `ad_oe` is 0.
- R9: In non-multiplexed mode, `mem_addr` carries the request address on every tick of the access. In multiplexed mode, and when idle, `mem_addr` is 0.
- R10: Every derived tick that exceeds C is clamped to C.
- R11: The mode flags, timing inputs, address, data and direction are captured when the request is accepted. Changes made to them during an access have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock; one tick per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| done | output | 1 | One-clock pulse on the last tick |
| rdata | output | DW | Last sampled read data |
| cfg_mux | input | 1 | 1 = address/data multiplexed on the data bus |
| cfg_we_sep | input | 1 | 1 = WE start from its own tick, 0 = from the write-data tick |
| cfg_cs_on | input | TW | Chip-select assertion tick |
| cfg_cs_wr_gap | input | TW | Ticks from WE deassertion to chip-select deassertion on writes |
| cfg_adv_on | input | TW | Address-valid assertion tick |
| cfg_adv_rd_off | input | TW | Address-valid deassertion tick, reads |
| cfg_adv_wr_off | input | TW | Address-valid deassertion tick, writes |
| cfg_addr_hold | input | TW | Address hold after address-valid deassertion (multiplexed) |
| cfg_oe_on | input | TW | Output-enable assertion tick |
| cfg_access | input | TW | Read sampling tick |
| cfg_wd_tick | input | TW | Tick where write data replaces address on the bus |
| cfg_we_on | input | TW | Write-enable assertion tick |
| cfg_we_off | input | TW | Write-enable deassertion tick |
| cfg_rd_cycle | input | TW | Read cycle length |
| cfg_wr_cycle | input | TW | Write cycle length |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | AW | Address bus (non-multiplexed mode) |
| ad_out | output | DW | Value driven onto the shared data bus |
| ad_oe | output | 1 | Drive enable for the shared data bus |
| ad_in | input | DW | Value read from the shared data bus |

## Verification
Two events can fall in the same clock. The first pair is the done pulse of one access and the acceptance of the next request. The bench raises the next request on the last tick. It then checks that tick 0 of the new access follows immediately, with the timing captured for that new request and with the previous read data still held. The second pair is the read-sampling tick and the cycle end. A directed case sets the access tick at or beyond the cycle length and checks that sampling is pulled to C-1, so that `rdata` already holds the value that was on the bus at that tick when `done` rises.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
  localparam int NWIN = 6;
  typedef enum int {
    W_CS   = 0,
    W_ADV  = 1,
    W_OE   = 2,
    W_WE   = 3,
    W_ABUS = 4,
    W_DBUS = 5
  } win_e;
endpackage

// File: rtl/ebs_sched_calc.sv
// Turns live configuration plus direction into clamped window edges.
module ebs_sched_calc
  import ebs_pkg::*;
#(
  parameter int TW = 5
) (
  input  logic                      is_wr,
  input  logic                      mux,
  input  logic                      we_sep,
  input  logic [TW-1:0]             cs_on,
  input  logic [TW-1:0]             cs_wr_gap,
  input  logic [TW-1:0]             adv_on,
  input  logic [TW-1:0]             adv_rd_off,
  input  logic [TW-1:0]             adv_wr_off,
  input  logic [TW-1:0]             addr_hold,
  input  logic [TW-1:0]             oe_on,
  input  logic [TW-1:0]             access,
  input  logic [TW-1:0]             wd_tick,
  input  logic [TW-1:0]             we_on,
  input  logic [TW-1:0]             we_off,
  input  logic [TW-1:0]             rd_cycle,
  input  logic [TW-1:0]             wr_cycle,
  output logic [NWIN-1:0][TW-1:0]   on_v,
  output logic [NWIN-1:0][TW-1:0]   off_v,
  output logic [TW-1:0]             acc_t,
  output logic [TW-1:0]             cyc_t
);
  localparam int EW = TW + 2;

  function automatic logic [EW-1:0] wid(input logic [TW-1:0] v);
    wid = EW'(v);
  endfunction

  function automatic logic [EW-1:0] mx(input logic [EW-1:0] a, input logic [EW-1:0] b);
    mx = (a > b) ? a : b;
  endfunction

  function automatic logic [TW-1:0] clip(input logic [EW-1:0] v, input logic [TW-1:0] lim);
    clip = (v > EW'(lim)) ? lim : v[TW-1:0];
  endfunction

  logic [TW-1:0] cyc, acc, adv_raw, adv_off, addr_end, oe_s, wd_s, we_s, we_e, csw_e, rd_end;

  always_comb begin
    cyc      = is_wr ? wr_cycle : rd_cycle;
    if (cyc == '0) cyc = TW'(1);
    acc      = clip(wid(access), cyc - TW'(1));
    rd_end   = acc + TW'(1);
    adv_raw  = is_wr ? adv_wr_off : adv_rd_off;
    adv_off  = clip(mux ? mx(wid(adv_raw), wid(adv_on) + EW'(1)) : wid(adv_raw), cyc);
    addr_end = mux ? clip(wid(adv_off) + wid(addr_hold), cyc) : '0;
    oe_s     = clip(mux ? mx(wid(oe_on), wid(addr_end)) : wid(oe_on), cyc);
    wd_s     = clip(mux ? mx(wid(wd_tick), wid(addr_end)) : wid(wd_tick), cyc);
    we_s     = we_sep ? clip(wid(we_on), cyc) : wd_s;
    we_e     = clip(wid(we_off), cyc);
    csw_e    = clip(wid(we_e) + wid(cs_wr_gap), cyc);

    on_v  = '0;
    off_v = '0;
    on_v[W_CS]    = clip(wid(cs_on), cyc);
    off_v[W_CS]   = is_wr ? csw_e : rd_end;
    on_v[W_ADV]   = clip(wid(adv_on), cyc);
    off_v[W_ADV]  = adv_off;
    off_v[W_ABUS] = addr_end;
    if (is_wr) begin
      on_v[W_WE]    = we_s;
      off_v[W_WE]   = we_e;
      on_v[W_DBUS]  = wd_s;
      off_v[W_DBUS] = csw_e;
    end else begin
      on_v[W_OE]    = oe_s;
      off_v[W_OE]   = rd_end;
    end
    acc_t = acc;
    cyc_t = cyc;
  end
endmodule

// File: rtl/ebs_tick_ctr.sv
// Access timeline counter: tick 0 follows the accepting edge.
module ebs_tick_ctr #(
  parameter int TW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [TW-1:0] cyc_len,
  output logic          busy,
  output logic [TW-1:0] tick,
  output logic          last
);
  assign last = busy && (tick == cyc_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      tick <= '0;
    end else if (start) begin
      busy <= 1'b1;
      tick <= '0;
    end else if (last) begin
      busy <= 1'b0;
    end else if (busy) begin
      tick <= tick + TW'(1);
    end
  end
endmodule

// File: rtl/ebs_window_dec.sv
// One half-open compare window per strobe/bus phase.
module ebs_window_dec
  import ebs_pkg::*;
#(
  parameter int TW = 5
) (
  input  logic                    busy,
  input  logic [TW-1:0]           tick,
  input  logic [NWIN-1:0][TW-1:0] on_v,
  input  logic [NWIN-1:0][TW-1:0] off_v,
  output logic [NWIN-1:0]         active
);
  for (genvar i = 0; i < NWIN; i++) begin : g_win
    assign active[i] = busy && (tick >= on_v[i]) && (tick < off_v[i]);
  end
endmodule

// File: rtl/ext_strobe_seq.sv
module ext_strobe_seq
  import ebs_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int TW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic [DW-1:0] rdata,
  input  logic          cfg_mux,
  input  logic          cfg_we_sep,
  input  logic [TW-1:0] cfg_cs_on,
  input  logic [TW-1:0] cfg_cs_wr_gap,
  input  logic [TW-1:0] cfg_adv_on,
  input  logic [TW-1:0] cfg_adv_rd_off,
  input  logic [TW-1:0] cfg_adv_wr_off,
  input  logic [TW-1:0] cfg_addr_hold,
  input  logic [TW-1:0] cfg_oe_on,
  input  logic [TW-1:0] cfg_access,
  input  logic [TW-1:0] cfg_wd_tick,
  input  logic [TW-1:0] cfg_we_on,
  input  logic [TW-1:0] cfg_we_off,
  input  logic [TW-1:0] cfg_rd_cycle,
  input  logic [TW-1:0] cfg_wr_cycle,
  output logic          mem_cs_n,
  output logic          mem_adv_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_in
);
  // live schedule from configuration
  logic [NWIN-1:0][TW-1:0] on_n, off_n;
  logic [TW-1:0]           acc_n, cyc_n;

  // captured schedule
  logic [NWIN-1:0][TW-1:0] on_q, off_q;
  logic [TW-1:0]           acc_q, cyc_q;
  logic                    wr_q, mux_q;
  logic [AW-1:0]           addr_q;
  logic [DW-1:0]           wdata_q;

  // named events for the checker
  logic                    busy_w, last_w, start_w, cap_w;
  logic [TW-1:0]           tick_w;
  logic [NWIN-1:0]         act_w;

  ebs_sched_calc #(.TW(TW)) u_calc (
    .is_wr(req_write), .mux(cfg_mux), .we_sep(cfg_we_sep),
    .cs_on(cfg_cs_on), .cs_wr_gap(cfg_cs_wr_gap),
    .adv_on(cfg_adv_on), .adv_rd_off(cfg_adv_rd_off), .adv_wr_off(cfg_adv_wr_off),
    .addr_hold(cfg_addr_hold), .oe_on(cfg_oe_on), .access(cfg_access),
    .wd_tick(cfg_wd_tick), .we_on(cfg_we_on), .we_off(cfg_we_off),
    .rd_cycle(cfg_rd_cycle), .wr_cycle(cfg_wr_cycle),
    .on_v(on_n), .off_v(off_n), .acc_t(acc_n), .cyc_t(cyc_n)
  );

  assign req_ready = !busy_w || last_w;
  assign start_w   = req_valid && req_ready;

  ebs_tick_ctr #(.TW(TW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .start(start_w), .cyc_len(cyc_q),
    .busy(busy_w), .tick(tick_w), .last(last_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q    <= '0;
      off_q   <= '0;
      acc_q   <= '0;
      cyc_q   <= TW'(1);
      wr_q    <= 1'b0;
      mux_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start_w) begin
      on_q    <= on_n;
      off_q   <= off_n;
      acc_q   <= acc_n;
      cyc_q   <= cyc_n;
      wr_q    <= req_write;
      mux_q   <= cfg_mux;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  ebs_window_dec #(.TW(TW)) u_win (
    .busy(busy_w), .tick(tick_w), .on_v(on_q), .off_v(off_q), .active(act_w)
  );

  assign cap_w = busy_w && !wr_q && (tick_w == acc_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (cap_w) rdata <= ad_in;
  end

  assign done      = last_w;
  assign mem_cs_n  = !act_w[W_CS];
  assign mem_adv_n = !act_w[W_ADV];
  assign mem_oe_n  = !act_w[W_OE];
  assign mem_we_n  = !act_w[W_WE];
  assign ad_oe     = act_w[W_ABUS] || act_w[W_DBUS];
  assign ad_out    = act_w[W_ABUS] ? addr_q[DW-1:0] :
                     (act_w[W_DBUS] ? wdata_q : '0);
  assign mem_addr  = (busy_w && !mux_q) ? addr_q : '0;
endmodule

// File: rtl/ebs_checker.sv
module ebs_checker #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy_w,
  input logic          cap_w,
  input logic          done,
  input logic          req_ready,
  input logic          mem_cs_n,
  input logic          mem_adv_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          ad_oe,
  input logic [DW-1:0] rdata
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_w |-> (mem_cs_n && mem_adv_n && mem_oe_n && mem_we_n && !ad_oe && !done));

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_ready_on_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  assert_rdata_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_w |=> $stable(rdata));

  assert_oe_we_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  assert_no_drive_on_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !ad_oe);
endmodule

bind ext_strobe_seq ebs_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_w(busy_w), .cap_w(cap_w), .done(done),
  .req_ready(req_ready), .mem_cs_n(mem_cs_n), .mem_adv_n(mem_adv_n),
  .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .ad_oe(ad_oe), .rdata(rdata)
);

// File: tb/tb_ext_strobe_seq.sv
`timescale 1ns/1ps
module tb_ext_strobe_seq;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int TW = 5;

  typedef struct {
    bit mux, sep;
    int cs_on, gap, adv_on, adv_rd, adv_wr, hold, oe_on, acc, wd, we_on, we_off, rd_cyc, wr_cyc;
  } bcfg_t;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, ad_in = '0;
  logic cfg_mux = 0, cfg_we_sep = 0;
  logic [TW-1:0] cfg_cs_on = 0, cfg_cs_wr_gap = 0, cfg_adv_on = 0, cfg_adv_rd_off = 0,
                 cfg_adv_wr_off = 0, cfg_addr_hold = 0, cfg_oe_on = 0, cfg_access = 0,
                 cfg_wd_tick = 0, cfg_we_on = 0, cfg_we_off = 0, cfg_rd_cycle = 0, cfg_wr_cycle = 0;
  logic req_ready, done, mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n, ad_oe;
  logic [DW-1:0] rdata, ad_out;
  logic [AW-1:0] mem_addr;

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  logic [DW-1:0] last_rd = '0;

  always #2 clk = ~clk;

  ext_strobe_seq #(.AW(AW), .DW(DW), .TW(TW)) dut (.*);

  function automatic int imin(int a, int b); return a < b ? a : b; endfunction
  function automatic int imax(int a, int b); return a > b ? a : b; endfunction
  function automatic bit inwin(int t, int s, int e); return (t >= s) && (t < e); endfunction
  function automatic logic [DW-1:0] pat(int t); return DW'(16'hC35A ^ (t * 16'h0111)); endfunction

  function automatic int cyc_of(bcfg_t c, bit wr);
    return imax(wr ? c.wr_cyc : c.rd_cyc, 1);
  endfunction

  function automatic int acc_of(bcfg_t c);
    return imin(c.acc, cyc_of(c, 0) - 1);
  endfunction

  // bit order: 0 cs,1 adv,2 oe,3 we,4 addr phase,5 data phase,6 done,7 ready
  function automatic logic [7:0] model(bcfg_t c, bit wr, int t);
    int cy, aoff, aend, rdend, oes, wds, wes, wee, cse;
    logic [7:0] f;
    cy    = cyc_of(c, wr);
    rdend = acc_of(c) + 1;
    aoff  = wr ? c.adv_wr : c.adv_rd;
    if (c.mux) aoff = imax(aoff, c.adv_on + 1);
    aoff  = imin(aoff, cy);
    aend  = c.mux ? imin(aoff + c.hold, cy) : 0;
    oes   = imin(c.mux ? imax(c.oe_on, aend) : c.oe_on, cy);
    wds   = imin(c.mux ? imax(c.wd, aend) : c.wd, cy);
    wes   = c.sep ? imin(c.we_on, cy) : wds;
    wee   = imin(c.we_off, cy);
    cse   = imin(wee + c.gap, cy);
    f[0]  = inwin(t, imin(c.cs_on, cy), wr ? cse : rdend);
    f[1]  = inwin(t, imin(c.adv_on, cy), aoff);
    f[2]  = !wr && inwin(t, oes, rdend);
    f[3]  = wr && inwin(t, wes, wee);
    f[4]  = inwin(t, 0, aend);
    f[5]  = wr && inwin(t, wds, cse);
    f[6]  = (t == cy);
    f[7]  = (t == cy);
    return f;
  endfunction

  task automatic chk(string tag, string ctx, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s [%s] actual=%0h expected=%0h at %0t", tag, ctx, act, exp, $time);
    end
  endtask

  task automatic apply_cfg(bcfg_t c);
    cfg_mux = c.mux; cfg_we_sep = c.sep;
    cfg_cs_on = TW'(c.cs_on); cfg_cs_wr_gap = TW'(c.gap); cfg_adv_on = TW'(c.adv_on);
    cfg_adv_rd_off = TW'(c.adv_rd); cfg_adv_wr_off = TW'(c.adv_wr); cfg_addr_hold = TW'(c.hold);
    cfg_oe_on = TW'(c.oe_on); cfg_access = TW'(c.acc); cfg_wd_tick = TW'(c.wd);
    cfg_we_on = TW'(c.we_on); cfg_we_off = TW'(c.we_off);
    cfg_rd_cycle = TW'(c.rd_cyc); cfg_wr_cycle = TW'(c.wr_cyc);
  endtask

  function automatic bcfg_t rnd_cfg();
    bcfg_t c;
    c.mux = 1'($urandom % 2); c.sep = 1'($urandom % 2);
    c.cs_on = $urandom % 6; c.gap = $urandom % 5; c.adv_on = $urandom % 5;
    c.adv_rd = $urandom % 8; c.adv_wr = $urandom % 8; c.hold = $urandom % 4;
    c.oe_on = $urandom % 10; c.acc = $urandom % 20; c.wd = $urandom % 10;
    c.we_on = $urandom % 10; c.we_off = $urandom % 18;
    c.rd_cyc = ($urandom % 8 == 0) ? $urandom % 32 : 6 + $urandom % 18;
    c.wr_cyc = ($urandom % 8 == 0) ? $urandom % 32 : 6 + $urandom % 18;
    return c;
  endfunction

  // Called at a negedge with req_ready expected high; returns at the negedge of the last tick.
  task automatic do_access(bcfg_t c, bit wr, logic [AW-1:0] a, logic [DW-1:0] d, string ctx);
    int cy;
    logic [7:0] f;
    cy = cyc_of(c, wr);
    apply_cfg(c);
    req_write = wr; req_addr = a; req_wdata = d; req_valid = 1;
    @(posedge clk);
    for (int t = 0; t <= cy; t++) begin
      @(negedge clk);
      if (t == 0) begin
        // R11: scramble every captured input during the access
        req_valid = 0; req_write = ~wr; req_addr = ~a; req_wdata = ~d;
        apply_cfg(rnd_cfg());
      end
      ad_in = pat(t);
      f = model(c, wr, t);
      chk("R3", ctx, 32'(mem_cs_n), 32'(!f[0]));
      chk("R4", ctx, 32'(mem_adv_n), 32'(!f[1]));
      chk("R6", ctx, 32'(mem_oe_n), 32'(!f[2]));
      chk("R7", ctx, 32'(mem_we_n), 32'(!f[3]));
      chk("R8", ctx, 32'(ad_oe), 32'(f[4] | f[5]));
      if (f[4]) chk("R8", ctx, 32'(ad_out), 32'(a[DW-1:0]));
      else if (f[5]) chk("R8", ctx, 32'(ad_out), 32'(d));
      chk("R9", ctx, 32'(mem_addr), c.mux ? 32'd0 : 32'(a));
      chk("R2", ctx, 32'(done), 32'(f[6]));
      chk("R2", ctx, 32'(req_ready), 32'(f[7]));
      if (t == cy) begin
        if (!wr) last_rd = pat(acc_of(c));
        chk("R5", ctx, 32'(rdata), 32'(last_rd));
      end
    end
  endtask

  task automatic idle_check(int n, string ctx);
    req_valid = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R1", ctx, {26'd0, mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n, ad_oe, done}, 32'h3C);
      chk("R1", ctx, 32'(req_ready), 32'd1);
      chk("R1", ctx, 32'(rdata), 32'(last_rd));
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(4 * 190000);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    bcfg_t c;
    void'($urandom(32'd7531));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    idle_check(2, "R1 reset");

    // non-multiplexed read
    c = '{mux:0, sep:0, cs_on:1, gap:1, adv_on:1, adv_rd:3, adv_wr:3, hold:1, oe_on:3,
          acc:7, wd:2, we_on:2, we_off:6, rd_cyc:10, wr_cyc:10};
    do_access(c, 0, 24'h12_3456, 16'h0, "read non-mux");
    idle_check(1, "R1 gap");
    // multiplexed write, separate WE tick
    c.mux = 1; c.sep = 1; c.we_on = 1; c.wd = 1;
    do_access(c, 1, 24'hAB_CDEF, 16'h5AA5, "write mux sep");
    // multiplexed write, WE tied to data tick; back-to-back (R2)
    c.sep = 0; c.hold = 2;
    do_access(c, 1, 24'h00_7777, 16'h1234, "R2 back-to-back write");
    // multiplexed read with OE pushed by address hold
    c.oe_on = 0; c.acc = 9;
    do_access(c, 0, 24'h55_0F0F, 16'h0, "R6 oe after hold");
    // clamp: every tick beyond a short cycle, access at C-1
    c = '{mux:1, sep:1, cs_on:31, gap:31, adv_on:31, adv_rd:31, adv_wr:31, hold:31, oe_on:31,
          acc:31, wd:31, we_on:31, we_off:31, rd_cyc:6, wr_cyc:6};
    do_access(c, 0, 24'h01_0203, 16'h0, "R10 clamp read");
    do_access(c, 1, 24'h01_0203, 16'hBEEF, "R10 clamp write");
    // zero cycle length treated as one
    c = '{mux:0, sep:1, cs_on:0, gap:0, adv_on:0, adv_rd:1, adv_wr:1, hold:0, oe_on:0,
          acc:0, wd:0, we_on:0, we_off:1, rd_cyc:0, wr_cyc:0};
    do_access(c, 0, 24'h00_0001, 16'h0, "R2 zero cycle read");
    do_access(c, 1, 24'h00_0002, 16'hFFFF, "R2 zero cycle write");
    idle_check(2, "R1 idle");

    for (int k = 0; k < 400; k++) begin
      c = rnd_cfg();
      do_access(c, 1'($urandom % 2), AW'($urandom), DW'($urandom), "R11 random");
      if ($urandom % 4 == 0) idle_check(1 + $urandom % 3, "R1 random idle");
    end
    idle_check(2, "R1 end");
    summary();
  end
endmodule